// File: doc/BRIEF.md
# Interrupt Context Save/Restore Engine

This block holds the OS-level interrupt context of one hardware thread: a context word with a valid flag (V), a hold-for-save flag (H) and a virtual-processor number, plus the live current priority (CPPR), the pending-priority bits (IPB) and a backlog byte (LSMFB). A small internal table keeps one record per virtual processor. Each record has two 32-bit words: an ownership word and a saved-state word.

When a context is pushed with V set, the engine reads the record. If the global save/restore enable and H are both set, the engine checks the record out to the requesting thread and restores the priority from it. In every case it then drains the record's stored pending bits into the live IPB. When a context is pulled, V is cleared and the old context word goes back to the requester. If save/restore applies, the engine checks ownership and writes the live registers back into the record, which checks it in. Each refused step raises a one-cycle error with a code. An exception output signals that a pending priority beats the current CPPR.

Requests are handled one at a time. A request is taken from an idle engine, `busy` covers the evaluation cycle, and `done` pulses once all effects are visible. The table is filled and inspected through a plain load port and an observation port.

Top module: `irq_ctx_sr_engine`

## Requirements
- R1: After reset, ctx_v, ctx_h, cppr, ipb, lsmfb, exc, busy, done, err_vld and err_code are all 0, and every table record reads as zero.
- R2: An accepted push loads V (bit 31 of push_word) and the VP number (bits VP_W-1:0). H (bit 30) is also loaded, except when ctx_v was already 1; H then keeps its old value.
- R3: An accepted pull returns the previous context word {V at bit 31, H at bit 30, VP in the low bits} on pull_data and clears ctx_v. No save takes place if the global enable or H is 0, or if V was already 0.
- R4: Ownership word layout: 31 valid, 30 hardware-owned, 29 checked-out, 28 thread-ID-valid, 27:26 privilege, 15:0 owner thread ID. Saved-state word layout: 31:24 IPB, 23:16 CPPR, 15:8 LSMFB. A permitted save writes the live IPB, CPPR and LSMFB into the saved-state word. It clears the checked-out bit, sets the owner ID to 0xFFFF and keeps the thread-ID-valid bit.
- R5: A save is refused, leaving the record unchanged, with err_code 1 if the VP number is at or above the table depth, 2 if the record is not valid, 3 if it is not hardware-owned, 4 if it is not checked out, and 5 if thread-ID-valid is set and the owner ID differs from thread_id.
- R6: A push with V=1, the enable on, H=1 and a valid hardware-owned record restores the live CPPR from the saved-state word and zeroes that field. It sets checked-out and thread-ID-valid to 1, the owner ID to thread_id and the privilege to 0.
- R7: A restore on a record that is valid but not hardware-owned is skipped with err_code 3, and the live CPPR stays unchanged.
- R8: A push with V=1 whose record is missing (err_code 1) or not valid (err_code 2) changes neither the record nor the live CPPR or IPB.
- R9: After any push with V=1 and a valid record, the record's stored IPB is ORed into the live IPB and cleared in the record, whether or not a restore took place.
- R10: exc is 1 exactly when IPB is non-zero and the index of its lowest set bit is numerically below CPPR.
- R11: A request is accepted only while busy is 0, and a push wins over a simultaneous pull. busy is 1 for the one cycle after acceptance. done then pulses for one cycle with busy 0. Requests presented while busy are ignored.
- R12: err_vld pulses only together with done and carries a non-zero err_code. At all other times err_code is 0.
- R13: cppr_wr_en loads cppr_wr_val, lsmfb_wr_en loads lsmfb_wr_val, and pend_post_en sets IPB bit pend_post_prio.
- R14: A push with V=0 neither reads nor changes any record and leaves the live IPB unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sr_enable | input | 1 | Global save/restore enable, sampled at acceptance |
| thread_id | input | TID_W | ID of the thread owning this context |
| push_req | input | 1 | Context push request |
| push_word | input | 32 | Context word to push |
| pull_req | input | 1 | Context pull request |
| pull_data | output | 32 | Context word returned by the last pull |
| cppr_wr_en | input | 1 | Direct CPPR write strobe |
| cppr_wr_val | input | PRIO_W | Direct CPPR write value |
| lsmfb_wr_en | input | 1 | Direct LSMFB write strobe |
| lsmfb_wr_val | input | PRIO_W | Direct LSMFB write value |
| pend_post_en | input | 1 | Post a pending priority |
| pend_post_prio | input | PIDX_W | Priority to mark pending |
| rec_ld_en | input | 1 | Table load strobe (idle only) |
| rec_ld_idx | input | IDX_W | Table load index |
| rec_ld_w1 | input | 32 | Ownership word to load |
| rec_ld_w2 | input | 32 | Saved-state word to load |
| rec_obs_idx | input | IDX_W | Table observation index |
| rec_obs_w1 | output | 32 | Observed ownership word |
| rec_obs_w2 | output | 32 | Observed saved-state word |
| ctx_v | output | 1 | Context valid |
| ctx_h | output | 1 | Context save/restore flag |
| ctx_vp | output | VP_W | Context VP number |
| cppr | output | PRIO_W | Current priority |
| ipb | output | NPRIO | Pending-priority bits |
| lsmfb | output | PRIO_W | Backlog byte |
| exc | output | 1 | Exception request |
| busy | output | 1 | Engine evaluating a request |
| done | output | 1 | Request completed |
| err_vld | output | 1 | Refusal pulse |
| err_code | output | 3 | Refusal code |

## Verification
The assertions assume that push and pull requests are honoured only from an idle engine. They also assume that table loads are never issued during evaluation, because the engine's own write would win. The stimulus therefore raises a request for a single edge, then waits for done before the next operation, and it loads records only between operations. The bench changes sr_enable only while the engine is idle, so a pull can be checked against a record that was checked out under another thread ID or never checked out.

// File: rtl/ictx_pkg.sv
package ictx_pkg;

   localparam int REC_W     = 32;
   localparam int OWN_TID_W = 16;

   // Context word
   localparam int CTX_V_BIT = 31;
   localparam int CTX_H_BIT = 30;

   // Ownership word
   localparam int O_VALID   = 31;
   localparam int O_HW      = 30;
   localparam int O_CO      = 29;
   localparam int O_TIDV    = 28;
   localparam int O_PRIV_LO = 26;
   localparam int O_TID_LO  = 0;

   // Saved-state word
   localparam int S_IPB_LO   = 24;
   localparam int S_CPPR_LO  = 16;
   localparam int S_LSMFB_LO = 8;

   typedef struct packed {
      logic [REC_W-1:0] own;
      logic [REC_W-1:0] st;
   } rec_t;

   typedef enum logic [2:0] {
      ERR_NONE     = 3'd0,
      ERR_NO_REC   = 3'd1,
      ERR_INVALID  = 3'd2,
      ERR_NOT_HW   = 3'd3,
      ERR_NOT_CO   = 3'd4,
      ERR_TID_MISM = 3'd5
   } err_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_EVAL = 1'b1
   } seq_e;

endpackage

// File: rtl/ictx_rec_table.sv
module ictx_rec_table
   import ictx_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  rec_t             wr_rec,
   input  logic [IDX_W-1:0] rd_idx,
   output rec_t             rd_rec,
   input  logic [IDX_W-1:0] obs_idx,
   output rec_t             obs_rec
);

   rec_t entry [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            entry[g] <= '0;
         else if (wr_en && wr_idx == IDX_W'(g))
            entry[g] <= wr_rec;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_rec <= '0;
      else
         rd_rec <= entry[rd_idx];
   end

   assign obs_rec = entry[obs_idx];

endmodule

// File: rtl/ictx_prio_eval.sv
module ictx_prio_eval #(
   parameter int NPRIO  = 8,
   parameter int PRIO_W = 8
) (
   input  logic [NPRIO-1:0]  ipb,
   input  logic [PRIO_W-1:0] cppr,
   output logic              exc
);

   logic [PRIO_W-1:0] best;

   always_comb begin
      best = '1;
      for (int i = NPRIO - 1; i >= 0; i--) begin
         if (ipb[i]) best = PRIO_W'(i);
      end
      exc = (|ipb) && (best < cppr);
   end

endmodule

// File: rtl/ictx_rec_update.sv
module ictx_rec_update
   import ictx_pkg::*;
#(
   parameter int NPRIO  = 8,
   parameter int PRIO_W = 8,
   parameter int TID_W  = 16
) (
   input  logic              is_push,
   input  logic              do_sr,
   input  logic              rec_exists,
   input  rec_t              rec,
   input  logic [TID_W-1:0]  thread_id,
   input  logic [NPRIO-1:0]  live_ipb,
   input  logic [PRIO_W-1:0] live_cppr,
   input  logic [PRIO_W-1:0] live_lsmfb,
   output logic              wr_en,
   output rec_t              new_rec,
   output err_e              err,
   output logic              cppr_load,
   output logic [PRIO_W-1:0] cppr_val,
   output logic [NPRIO-1:0]  ipb_merge
);

   logic [OWN_TID_W-1:0] tid_ext;
   assign tid_ext = OWN_TID_W'(thread_id);

   always_comb begin
      new_rec   = rec;
      wr_en     = 1'b0;
      err       = ERR_NONE;
      cppr_load = 1'b0;
      cppr_val  = rec.st[S_CPPR_LO +: PRIO_W];
      ipb_merge = '0;
      if (is_push) begin
         if (!rec_exists)
            err = ERR_NO_REC;
         else if (!rec.own[O_VALID])
            err = ERR_INVALID;
         else begin
            if (do_sr) begin
               if (!rec.own[O_HW])
                  err = ERR_NOT_HW;
               else begin
                  cppr_load                         = 1'b1;
                  new_rec.st[S_CPPR_LO +: PRIO_W]   = '0;
                  new_rec.own[O_CO]                 = 1'b1;
                  new_rec.own[O_TIDV]               = 1'b1;
                  new_rec.own[O_PRIV_LO +: 2]       = 2'd0;
                  new_rec.own[O_TID_LO +: OWN_TID_W] = tid_ext;
                  wr_en                             = 1'b1;
               end
            end
            ipb_merge = rec.st[S_IPB_LO +: NPRIO];
            if (|ipb_merge) begin
               new_rec.st[S_IPB_LO +: NPRIO] = '0;
               wr_en                         = 1'b1;
            end
         end
      end else if (do_sr) begin
         if (!rec_exists)
            err = ERR_NO_REC;
         else if (!rec.own[O_VALID])
            err = ERR_INVALID;
         else if (!rec.own[O_HW])
            err = ERR_NOT_HW;
         else if (!rec.own[O_CO])
            err = ERR_NOT_CO;
         else if (rec.own[O_TIDV] && rec.own[O_TID_LO +: OWN_TID_W] != tid_ext)
            err = ERR_TID_MISM;
         else begin
            new_rec.st[S_IPB_LO +: 8]       = 8'(live_ipb);
            new_rec.st[S_CPPR_LO +: 8]      = 8'(live_cppr);
            new_rec.st[S_LSMFB_LO +: 8]     = 8'(live_lsmfb);
            new_rec.own[O_CO]               = 1'b0;
            new_rec.own[O_TID_LO +: OWN_TID_W] = '1;
            wr_en                           = 1'b1;
         end
      end
   end

endmodule

// File: rtl/irq_ctx_sr_engine.sv
module irq_ctx_sr_engine
   import ictx_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int VP_W   = 6,
   parameter int TID_W  = 16,
   parameter int NPRIO  = 8,
   parameter int PRIO_W = 8,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int PIDX_W = $clog2(NPRIO)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sr_enable,
   input  logic [TID_W-1:0]  thread_id,
   input  logic              push_req,
   input  logic [31:0]       push_word,
   input  logic              pull_req,
   output logic [31:0]       pull_data,
   input  logic              cppr_wr_en,
   input  logic [PRIO_W-1:0] cppr_wr_val,
   input  logic              lsmfb_wr_en,
   input  logic [PRIO_W-1:0] lsmfb_wr_val,
   input  logic              pend_post_en,
   input  logic [PIDX_W-1:0] pend_post_prio,
   input  logic              rec_ld_en,
   input  logic [IDX_W-1:0]  rec_ld_idx,
   input  logic [31:0]       rec_ld_w1,
   input  logic [31:0]       rec_ld_w2,
   input  logic [IDX_W-1:0]  rec_obs_idx,
   output logic [31:0]       rec_obs_w1,
   output logic [31:0]       rec_obs_w2,
   output logic              ctx_v,
   output logic              ctx_h,
   output logic [VP_W-1:0]   ctx_vp,
   output logic [PRIO_W-1:0] cppr,
   output logic [NPRIO-1:0]  ipb,
   output logic [PRIO_W-1:0] lsmfb,
   output logic              exc,
   output logic              busy,
   output logic              done,
   output logic              err_vld,
   output logic [2:0]        err_code
);

   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (VP_W <= IDX_W || VP_W > 30) begin : g_bad_vp
      $error("VP_W must exceed the table index width and fit below bit 30");
   end
   if (TID_W < 1 || TID_W > OWN_TID_W) begin : g_bad_tid
      $error("TID_W must be 1..16");
   end
   if (NPRIO < 2 || NPRIO > 8 || (1 << PIDX_W) != NPRIO) begin : g_bad_nprio
      $error("NPRIO must be a power of two from 2 to 8");
   end
   if (PRIO_W < PIDX_W || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must cover a priority index and fit in 8 bits");
   end

   seq_e              state;
   logic              op_push, op_sr, op_exists, op_active;
   logic              acc_push, acc_pull;
   logic [IDX_W-1:0]  rd_idx;
   logic [VP_W-1:0]   req_vp;
   rec_t              rd_rec, obs_rec, upd_rec, wr_rec;
   logic              upd_wr, tbl_wr;
   logic [IDX_W-1:0]  wr_idx;
   err_e              upd_err;
   logic              upd_cppr_load;
   logic [PRIO_W-1:0] upd_cppr_val;
   logic [NPRIO-1:0]  upd_merge;
   logic              apply;
   logic [31:0]       ctx_word;
   logic              unused_hi;

   assign unused_hi = ^push_word[29:VP_W];

   assign busy     = (state == ST_EVAL);
   assign acc_push = !busy && push_req;
   assign acc_pull = !busy && !push_req && pull_req;
   assign req_vp   = acc_push ? push_word[VP_W-1:0] : ctx_vp;
   assign rd_idx   = req_vp[IDX_W-1:0];
   assign apply    = busy && op_active;

   always_comb begin
      ctx_word            = '0;
      ctx_word[CTX_V_BIT] = ctx_v;
      ctx_word[CTX_H_BIT] = ctx_h;
      ctx_word[VP_W-1:0]  = ctx_vp;
   end

   ictx_rec_table #(.DEPTH(DEPTH)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_wr),
      .wr_idx  (wr_idx),
      .wr_rec  (wr_rec),
      .rd_idx  (rd_idx),
      .rd_rec  (rd_rec),
      .obs_idx (rec_obs_idx),
      .obs_rec (obs_rec)
   );

   ictx_rec_update #(.NPRIO(NPRIO), .PRIO_W(PRIO_W), .TID_W(TID_W)) u_update (
      .is_push    (op_push),
      .do_sr      (op_sr),
      .rec_exists (op_exists),
      .rec        (rd_rec),
      .thread_id  (thread_id),
      .live_ipb   (ipb),
      .live_cppr  (cppr),
      .live_lsmfb (lsmfb),
      .wr_en      (upd_wr),
      .new_rec    (upd_rec),
      .err        (upd_err),
      .cppr_load  (upd_cppr_load),
      .cppr_val   (upd_cppr_val),
      .ipb_merge  (upd_merge)
   );

   ictx_prio_eval #(.NPRIO(NPRIO), .PRIO_W(PRIO_W)) u_prio (
      .ipb  (ipb),
      .cppr (cppr),
      .exc  (exc)
   );

   // engine write takes the port over any table load
   assign tbl_wr = (apply && upd_wr) || rec_ld_en;
   assign wr_idx = (apply && upd_wr) ? ctx_vp[IDX_W-1:0] : rec_ld_idx;
   assign wr_rec = (apply && upd_wr) ? upd_rec : rec_t'({rec_ld_w1, rec_ld_w2});

   assign rec_obs_w1 = obs_rec.own;
   assign rec_obs_w2 = obs_rec.st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         op_push   <= 1'b0;
         op_sr     <= 1'b0;
         op_exists <= 1'b0;
         op_active <= 1'b0;
         ctx_v     <= 1'b0;
         ctx_h     <= 1'b0;
         ctx_vp    <= '0;
         pull_data <= '0;
         done      <= 1'b0;
         err_vld   <= 1'b0;
         err_code  <= ERR_NONE;
      end else begin
         done     <= 1'b0;
         err_vld  <= 1'b0;
         err_code <= ERR_NONE;
         if (acc_push) begin
            state     <= ST_EVAL;
            op_push   <= 1'b1;
            op_active <= push_word[CTX_V_BIT];
            op_exists <= ~|push_word[VP_W-1:IDX_W];
            op_sr     <= sr_enable && (ctx_v ? ctx_h : push_word[CTX_H_BIT]);
            ctx_v     <= push_word[CTX_V_BIT];
            ctx_vp    <= push_word[VP_W-1:0];
            if (!ctx_v) ctx_h <= push_word[CTX_H_BIT];
         end else if (acc_pull) begin
            state     <= ST_EVAL;
            op_push   <= 1'b0;
            op_active <= ctx_v;
            op_exists <= ~|ctx_vp[VP_W-1:IDX_W];
            op_sr     <= sr_enable && ctx_h;
            pull_data <= ctx_word;
            ctx_v     <= 1'b0;
         end else if (busy) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            if (op_active && upd_err != ERR_NONE) begin
               err_vld  <= 1'b1;
               err_code <= upd_err;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cppr  <= '0;
         ipb   <= '0;
         lsmfb <= '0;
      end else begin
         if (apply && upd_cppr_load)
            cppr <= upd_cppr_val;
         else if (cppr_wr_en)
            cppr <= cppr_wr_val;
         if (lsmfb_wr_en)
            lsmfb <= lsmfb_wr_val;
         ipb <= ipb
              | (pend_post_en ? (NPRIO'(1) << pend_post_prio) : '0)
              | (apply ? upd_merge : '0);
      end
   end

endmodule

// File: rtl/ictx_chk.sv
module ictx_chk #(
   parameter int NPRIO = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             push_req,
   input logic             pull_req,
   input logic             busy,
   input logic             done,
   input logic             err_vld,
   input logic [2:0]       err_code,
   input logic             ctx_v,
   input logic             ctx_h,
   input logic             exc,
   input logic [NPRIO-1:0] ipb
);

   // R2
   h_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && push_req && ctx_v) |=> (ctx_h == $past(ctx_h)));

   // R3
   pull_clears_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !push_req && pull_req) |=> !ctx_v);

   // R10
   exc_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc |-> (ipb != '0));

   // R11
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   busy_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> done);

   // R12
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_vld |-> (done && err_code != 3'd0));

   // R12
   err_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !err_vld |-> (err_code == 3'd0));

endmodule

bind irq_ctx_sr_engine ictx_chk #(.NPRIO(NPRIO)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .push_req (push_req),
   .pull_req (pull_req),
   .busy     (busy),
   .done     (done),
   .err_vld  (err_vld),
   .err_code (err_code),
   .ctx_v    (ctx_v),
   .ctx_h    (ctx_h),
   .exc      (exc),
   .ipb      (ipb)
);

// File: tb/tb_irq_ctx_sr_engine.sv
module tb_irq_ctx_sr_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sr_enable = 1'b1;
   logic [15:0] thread_id = 16'h0042;
   logic        push_req = 1'b0;
   logic [31:0] push_word = '0;
   logic        pull_req = 1'b0;
   logic [31:0] pull_data;
   logic        cppr_wr_en = 1'b0;
   logic [7:0]  cppr_wr_val = '0;
   logic        lsmfb_wr_en = 1'b0;
   logic [7:0]  lsmfb_wr_val = '0;
   logic        pend_post_en = 1'b0;
   logic [2:0]  pend_post_prio = '0;
   logic        rec_ld_en = 1'b0;
   logic [3:0]  rec_ld_idx = '0;
   logic [31:0] rec_ld_w1 = '0;
   logic [31:0] rec_ld_w2 = '0;
   logic [3:0]  rec_obs_idx = '0;
   logic [31:0] rec_obs_w1, rec_obs_w2;
   logic        ctx_v, ctx_h;
   logic [5:0]  ctx_vp;
   logic [7:0]  cppr, lsmfb;
   logic [7:0]  ipb;
   logic        exc, busy, done, err_vld;
   logic [2:0]  err_code;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   irq_ctx_sr_engine dut (
      .clk(clk), .rst_n(rst_n), .sr_enable(sr_enable), .thread_id(thread_id),
      .push_req(push_req), .push_word(push_word), .pull_req(pull_req),
      .pull_data(pull_data), .cppr_wr_en(cppr_wr_en), .cppr_wr_val(cppr_wr_val),
      .lsmfb_wr_en(lsmfb_wr_en), .lsmfb_wr_val(lsmfb_wr_val),
      .pend_post_en(pend_post_en), .pend_post_prio(pend_post_prio),
      .rec_ld_en(rec_ld_en), .rec_ld_idx(rec_ld_idx), .rec_ld_w1(rec_ld_w1),
      .rec_ld_w2(rec_ld_w2), .rec_obs_idx(rec_obs_idx), .rec_obs_w1(rec_obs_w1),
      .rec_obs_w2(rec_obs_w2), .ctx_v(ctx_v), .ctx_h(ctx_h), .ctx_vp(ctx_vp),
      .cppr(cppr), .ipb(ipb), .lsmfb(lsmfb), .exc(exc), .busy(busy),
      .done(done), .err_vld(err_vld), .err_code(err_code)
   );

   // vector: [12] post, [11:9] post prio, [8:1] cppr, [0] expected exc
   localparam logic [12:0] VEC [8] = '{
      {1'b0, 3'd0, 8'd5,   1'b0},
      {1'b1, 3'd6, 8'd5,   1'b0},
      {1'b0, 3'd0, 8'd7,   1'b1},
      {1'b0, 3'd0, 8'd6,   1'b0},
      {1'b1, 3'd3, 8'd4,   1'b1},
      {1'b0, 3'd0, 8'd3,   1'b0},
      {1'b0, 3'd0, 8'd0,   1'b0},
      {1'b0, 3'd0, 8'hFF,  1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic load_rec(input logic [3:0] idx, input logic [31:0] w1, input logic [31:0] w2);
      @(negedge clk);
      rec_ld_en = 1'b1; rec_ld_idx = idx; rec_ld_w1 = w1; rec_ld_w2 = w2;
      @(negedge clk);
      rec_ld_en = 1'b0;
   endtask

   // drives one request and returns at the negedge where done is high
   task automatic do_op(input logic is_push, input logic [31:0] word);
      @(negedge clk);
      if (is_push) begin push_req = 1'b1; push_word = word; end
      else pull_req = 1'b1;
      @(negedge clk);
      push_req = 1'b0; pull_req = 1'b0;
      for (int k = 0; k < 8 && !done; k++) @(negedge clk);
   endtask

   task automatic obs(input logic [3:0] idx);
      rec_obs_idx = idx;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 ctx", {ctx_v, ctx_h, busy, done, err_vld, exc}, 0);
      chk("R1 regs", {cppr, ipb, lsmfb, 5'd0, err_code}, 0);
      obs(4'd2);
      chk("R1 table", rec_obs_w1 | rec_obs_w2, 0);

      // R10 R13 vector walk
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         cppr_wr_en = 1'b1; cppr_wr_val = VEC[i][8:1];
         pend_post_en = VEC[i][12]; pend_post_prio = VEC[i][11:9];
         @(negedge clk);
         cppr_wr_en = 1'b0; pend_post_en = 1'b0;
         chk("R10 exc", 32'(exc), 32'(VEC[i][0]));
         chk("R13 cppr", 32'(cppr), 32'(VEC[i][8:1]));
      end
      chk("R13 ipb", 32'(ipb), 32'h48);

      do_reset();
      load_rec(4'd2, 32'hC000_0000, 32'h1006_0000);

      // R6 R9 restore
      do_op(1'b1, 32'hC000_0002);
      chk("R2 v/h/vp", {ctx_v, ctx_h, 24'd0, ctx_vp}, 32'hC000_0002);
      chk("R6 cppr", 32'(cppr), 32'h06);
      chk("R9 ipb", 32'(ipb), 32'h10);
      chk("R10 exc", 32'(exc), 1);
      obs(4'd2);
      chk("R6 own", rec_obs_w1, 32'hF000_0042);
      chk("R6 st", rec_obs_w2, 32'h0);
      chk("R12 no err", {err_vld, err_code}, 0);

      // R2 H locked while V=1
      do_op(1'b1, 32'h8000_0002);
      chk("R2 h kept", 32'(ctx_h), 1);
      chk("R6 cppr zero restored", 32'(cppr), 0);

      // R13 direct writes
      @(negedge clk);
      cppr_wr_en = 1'b1; cppr_wr_val = 8'h05;
      lsmfb_wr_en = 1'b1; lsmfb_wr_val = 8'h33;
      pend_post_en = 1'b1; pend_post_prio = 3'd1;
      @(negedge clk);
      cppr_wr_en = 1'b0; lsmfb_wr_en = 1'b0; pend_post_en = 1'b0;
      chk("R13 ipb post", 32'(ipb), 32'h12);
      chk("R13 lsmfb", 32'(lsmfb), 32'h33);

      // R3 R4 save
      do_op(1'b0, 0);
      chk("R3 pull data", pull_data, 32'hC000_0002);
      chk("R3 v cleared", 32'(ctx_v), 0);
      obs(4'd2);
      chk("R4 st", rec_obs_w2, 32'h1205_3300);
      chk("R4 own", rec_obs_w1, 32'hD000_FFFF);

      // R3 pull with V=0: no save
      do_op(1'b0, 0);
      chk("R3 pull v0 data", pull_data, 32'h4000_0002);
      chk("R3 pull v0 err", {err_vld, err_code}, 0);

      // R9 merge without restore (H=0)
      do_op(1'b1, 32'h8000_0002);
      chk("R2 h loaded", 32'(ctx_h), 0);
      chk("R9 ipb", 32'(ipb), 32'h12);
      chk("R9 cppr kept", 32'(cppr), 32'h05);
      obs(4'd2);
      chk("R9 st cleared", rec_obs_w2, 32'h0005_3300);
      chk("R9 own kept", rec_obs_w1, 32'hD000_FFFF);

      do_op(1'b0, 0);
      chk("R3 no save H0", rec_obs_w2, 32'h0005_3300);

      // R8 R5 missing record
      do_op(1'b1, 32'hC000_0014);
      chk("R8 no rec", {err_vld, err_code}, {1'b1, 3'd1});
      chk("R8 ipb", 32'(ipb), 32'h12);
      do_op(1'b0, 0);
      chk("R5 no rec", {err_vld, err_code}, {1'b1, 3'd1});

      // R8 R5 invalid record
      load_rec(4'd3, 32'h0, 32'h0100_0000);
      do_op(1'b1, 32'hC000_0003);
      chk("R8 invalid", {err_vld, err_code}, {1'b1, 3'd2});
      obs(4'd3);
      chk("R8 rec kept", rec_obs_w2, 32'h0100_0000);
      do_op(1'b0, 0);
      chk("R5 invalid", {err_vld, err_code}, {1'b1, 3'd2});

      // R7 R5 not hardware-owned
      load_rec(4'd4, 32'h8000_0000, 32'h0009_0000);
      do_op(1'b1, 32'hC000_0004);
      chk("R7 not hw", {err_vld, err_code}, {1'b1, 3'd3});
      chk("R7 cppr kept", 32'(cppr), 32'h05);
      do_op(1'b0, 0);
      chk("R5 not hw", {err_vld, err_code}, {1'b1, 3'd3});

      // R5 not checked out
      load_rec(4'd5, 32'hC000_0000, 32'h0);
      sr_enable = 1'b0;
      do_op(1'b1, 32'hC000_0005);
      sr_enable = 1'b1;
      do_op(1'b0, 0);
      chk("R5 not co", {err_vld, err_code}, {1'b1, 3'd4});
      obs(4'd5);
      chk("R5 not co kept", rec_obs_w1, 32'hC000_0000);

      // R5 thread mismatch
      load_rec(4'd6, 32'hF000_0099, 32'h0007_0000);
      sr_enable = 1'b0;
      do_op(1'b1, 32'hC000_0006);
      sr_enable = 1'b1;
      do_op(1'b0, 0);
      chk("R5 tid mismatch", {err_vld, err_code}, {1'b1, 3'd5});
      obs(4'd6);
      chk("R5 tid kept", rec_obs_w1, 32'hF000_0099);

      // R4 owner ID ignored when thread-ID-valid is 0
      load_rec(4'd7, 32'hE000_0099, 32'h0);
      sr_enable = 1'b0;
      do_op(1'b1, 32'hC000_0007);
      sr_enable = 1'b1;
      do_op(1'b0, 0);
      chk("R4 tidv0 err", {err_vld, err_code}, 0);
      obs(4'd7);
      chk("R4 tidv0 own", rec_obs_w1, 32'hC000_FFFF);
      chk("R4 tidv0 st", rec_obs_w2, 32'h1205_3300);

      // R11 busy/done timing, request while busy ignored
      @(negedge clk);
      push_req = 1'b1; push_word = 32'h8000_0002;
      @(negedge clk);
      push_req = 1'b0;
      chk("R11 busy", {busy, done}, 2'b10);
      pull_req = 1'b1;
      @(negedge clk);
      pull_req = 1'b0;
      chk("R11 done", {busy, done}, 2'b01);
      chk("R11 ignored pull", 32'(ctx_v), 1);
      @(negedge clk);
      chk("R11 done once", 32'(done), 0);

      // R14 push with V=0 leaves record alone
      do_op(1'b1, 32'h4000_0007);
      obs(4'd7);
      chk("R14 rec kept", rec_obs_w2, 32'h1205_3300);
      chk("R14 ipb kept", 32'(ipb), 32'h12);
      chk("R14 v", 32'(ctx_v), 0);

      summary();
      $finish;
   end

endmodule